// File: doc/BRIEF.md
# ROM Signature Tester

This block is a built-in self-test engine for a read-only memory. On a start request it reads the memory from address zero upwards and folds every returned word into a multiple-input linear feedback shift register. When the last word has been folded in, it compares the remaining K-bit signature with a known-good value that is fixed when the block is built. A single-cycle done pulse reports the end of the run, and a pass flag gives the verdict.

The whole content of a memory with 2^N words of M bits is reduced to one K-bit value, so the tester needs no reference copy of the data. Faults that corrupt the read stream change the signature with high probability. These include a data line stuck at a level, an address line stuck at a level, two address lines bridged together, and a wrong stored word. The memory is expected to return the word for an address on the clock edge after that address is driven, which is one cycle of read latency.

Top module: `rsig_tester`

## Requirements
- R1: While reset is held and right after it, done_o is 0, pass_o is 0 and rom_addr_o is 0.
- R2: A start request accepted on a clock edge puts address 0 on rom_addr_o after that edge. The address then rises by one on every following edge up to 2^N−1 and stays there until the next accepted start.
- R3: The word on rom_data_i is taken one clock after its address was driven. The word for address A is folded in on the edge A+2 counted from the edge that accepted start.
- R4: An accepted start loads the signature register with all ones, so each run is independent of the run before it.
- R5: Each word is folded in with the polynomial x^16+x^12+x^5+1 (0x1021), most significant data bit first, with all M bits in one clock.
- R6: done_o is high for exactly one clock cycle. That cycle follows the edge numbered 2^N+1 after the edge that accepted start.
- R7: pass_o is 1 during the done cycle exactly when the final signature equals GOLDEN. It keeps that value until the next done cycle.
- R8: A start request while a run is in progress is ignored. The address sequence, the result and the done timing stay as for the first start, and no second done follows.
- R9: A start request in the done cycle is accepted and begins a new run. The verdict shown in that done cycle still belongs to the finished run.
- R10: Any of these faults in the read path makes pass_o 0: data bit 3 stuck at 1, address bit 1 stuck at 0, address bits 0 and 2 shorted as a wired AND, or one word altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a test run |
| rom_addr_o | output | ADDR_W | Address driven to the memory under test |
| rom_data_i | input | DATA_W | Word returned by the memory one cycle after its address |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Verdict: final signature matched GOLDEN |

## Verification
The done cycle of one run and the acceptance of the next start can fall in the same cycle. In that cycle the signature register is reseeded, while the verdict that is showing must still come from the old signature. The bench raises start while done_o is high, right after a run seeded with a corrupted word. The scoreboard expects a fail verdict in that cycle, then a pass verdict with correct done timing for the new run. The bench also pokes start in the middle of a run and expects neither a restart nor a stray done.

// File: rtl/rsig_pkg.sv
// Shared definitions for the ROM signature tester.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package rsig_pkg;

    // Sequencer phase: idle, or issuing addresses to the memory.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ISSUE = 1'b1
    } rsig_phase_t;

    // Default feedback taps for x^16+x^12+x^5+1.
    localparam logic [15:0] CCITT_TAPS = 16'h1021;

endpackage

// File: rtl/rsig_seq.sv
// Address sequencer: walks 0..2^ADDR_W-1 once per accepted start and
// marks the cycle in which each returned word is valid.
// Assumes: memory read latency of exactly one clock; start requests
// while a run is in flight are dropped.
module rsig_seq
    import rsig_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              issue_o,
    output logic              seed_o,
    output logic              absorb_o,
    output logic              absorb_last_o
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

    rsig_phase_t       phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic              vld_q;
    logic              last_q;
    logic              accept;

    // A start is taken only when no address or word is in flight.
    assign accept = start_i && (phase_q == PH_IDLE) && !vld_q;

    // Advance the address walk and delay the issue flags by the read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
            vld_q   <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            vld_q  <= (phase_q == PH_ISSUE);
            last_q <= (phase_q == PH_ISSUE) && (addr_q == ADDR_MAX);
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        addr_q  <= '0;
                        phase_q <= PH_ISSUE;
                    end
                end
                PH_ISSUE: begin
                    if (addr_q == ADDR_MAX) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign addr_o        = addr_q;
    assign issue_o       = (phase_q == PH_ISSUE);
    assign seed_o        = accept;
    assign absorb_o      = vld_q;
    assign absorb_last_o = vld_q && last_q;

endmodule

// File: rtl/rsig_misr.sv
// Multiple-input signature register: folds one DATA_W-bit word per clock
// into a SIG_W-bit LFSR, data MSB first, feedback taps POLY.
// Assumes: seed and absorb never coincide (guaranteed by the sequencer).
module rsig_misr #(
    parameter int               SIG_W  = 16,
    parameter int               DATA_W = 16,
    parameter logic [SIG_W-1:0] POLY   = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_i,
    input  logic              absorb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [SIG_W-1:0]  sig_o
);
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] sig_nxt;

    // One serial LFSR step per data bit, unrolled across the whole word.
    function automatic logic [SIG_W-1:0] fold_word(
        input logic [SIG_W-1:0]  s,
        input logic [DATA_W-1:0] w
    );
        logic [SIG_W-1:0] r;
        logic             fb;
        r = s;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb = r[SIG_W-1] ^ w[b];
            r  = {r[SIG_W-2:0], 1'b0};
            if (fb) begin
                r = r ^ POLY;
            end
        end
        return r;
    endfunction

    // Next signature for the word currently on the data input.
    always_comb begin
        sig_nxt = fold_word(sig_q, data_i);
    end

    // Load all ones on seed, otherwise absorb valid words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= '1;
        end else if (seed_i) begin
            sig_q <= '1;
        end else if (absorb_i) begin
            sig_q <= sig_nxt;
        end
    end

    assign sig_o = sig_q;

endmodule

// File: rtl/rsig_cmp.sv
// Signature compare: raises done for one cycle after the final word and
// shows the verdict, then holds the verdict until the next done.
// Assumes: the signature input is final during the done cycle.
module rsig_cmp #(
    parameter int               SIG_W  = 16,
    parameter logic [SIG_W-1:0] GOLDEN = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             absorb_last_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic             done_o,
    output logic             pass_o
);
    logic done_q;
    logic hold_q;
    logic match;

    assign match = (sig_i == GOLDEN);

    // Time the done pulse and latch the verdict at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            done_q <= absorb_last_i;
            if (done_q) begin
                hold_q <= match;
            end
        end
    end

    assign done_o = done_q;
    assign pass_o = done_q ? match : hold_q;

endmodule

// File: rtl/rsig_tester.sv
// ROM signature tester top: sequencer, signature register and compare.
// Assumes: the memory returns the word one clock after the address.
module rsig_tester
    import rsig_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 16,
    parameter int                SIG_W  = 16,
    parameter logic [SIG_W-1:0]  POLY   = CCITT_TAPS,
    parameter logic [SIG_W-1:0]  GOLDEN = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic [DATA_W-1:0] rom_data_i,
    output logic              done_o,
    output logic              pass_o
);
    logic             issue_w;
    logic             seed_w;
    logic             absorb_w;
    logic             absorb_last_w;
    logic [SIG_W-1:0] sig_w;

    rsig_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .addr_o       (rom_addr_o),
        .issue_o      (issue_w),
        .seed_o       (seed_w),
        .absorb_o     (absorb_w),
        .absorb_last_o(absorb_last_w)
    );

    rsig_misr #(
        .SIG_W (SIG_W),
        .DATA_W(DATA_W),
        .POLY  (POLY)
    ) u_misr (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_w),
        .absorb_i(absorb_w),
        .data_i  (rom_data_i),
        .sig_o   (sig_w)
    );

    rsig_cmp #(
        .SIG_W (SIG_W),
        .GOLDEN(GOLDEN)
    ) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .absorb_last_i(absorb_last_w),
        .sig_i        (sig_w),
        .done_o       (done_o),
        .pass_o       (pass_o)
    );

endmodule

// File: rtl/rsig_tester_chk.sv
// Property checker for rsig_tester, attached with bind.
module rsig_tester_chk #(
    parameter int ADDR_W = 8,
    parameter int SIG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              issue,
    input logic              absorb,
    input logic [SIG_W-1:0]  sig
);
    logic busy;
    assign busy = issue || absorb;

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && $past(issue)) |-> (rom_addr_o == $past(rom_addr_o) + 1'b1))
        else $error("address did not step by one");

    assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (issue && rom_addr_o == '0))
        else $error("run did not begin at address zero");

    assert_seed_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (sig == {SIG_W{1'b1}}))
        else $error("signature not seeded with ones");

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    assert_pass_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_o) |-> done_o)
        else $error("verdict changed outside done");

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && issue && rom_addr_o != '0) |=> (rom_addr_o != '0))
        else $error("start restarted a busy run");

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy)
        else $error("done while still busy");

endmodule

bind rsig_tester rsig_tester_chk #(
    .ADDR_W(ADDR_W),
    .SIG_W (SIG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rom_addr_o(rom_addr_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .issue     (issue_w),
    .absorb    (absorb_w),
    .sig       (sig_w)
);

// File: tb/test_rsig_tester.sv
`timescale 1ns/1ps
module test_rsig_tester;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int WORDS  = 1 << ADDR_W;

    // Fault-free content of the memory model.
    function automatic logic [7:0] rom_word(input logic [4:0] a);
        logic [7:0] v;
        v = {3'b000, a} * 8'd29 + 8'h5B;
        return v;
    endfunction

    // Read path with an injected fault (0: none).
    function automatic logic [7:0] faulty_read(input logic [4:0] a_in, input int mode);
        logic [4:0] a;
        logic [7:0] d;
        logic       t;
        a = a_in;
        if (mode == 2) a[1] = 1'b0;
        if (mode == 3) begin
            t = a[0] & a[2];
            a[0] = t;
            a[2] = t;
        end
        d = rom_word(a);
        if (mode == 1) d[3] = 1'b1;
        if (mode == 4 && a == 5'd17) d = d ^ 8'h40;
        return d;
    endfunction

    // Expected signature in byte-wise CRC form, seeded with ones.
    function automatic logic [15:0] stream_sig(input int mode);
        logic [15:0] s;
        s = 16'hFFFF;
        for (int a = 0; a < WORDS; a++) begin
            s = s ^ {faulty_read(a[4:0], mode), 8'h00};
            for (int k = 0; k < 8; k++) begin
                s = s[15] ? ((s << 1) ^ 16'h1021) : (s << 1);
            end
        end
        return s;
    endfunction

    localparam logic [15:0] GOOD = stream_sig(0);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] rom_addr_o;
    logic [DATA_W-1:0] rom_q = '0;
    logic              done_o;
    logic              pass_o;
    int                fault_mode = 0;
    int                cyc = 0;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                exp_pass_q[$];
    int                exp_cyc_q[$];
    bit                prev_done = 1'b0;
    bit                last_pass = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model with one cycle of read latency.
    always @(posedge clk) rom_q <= faulty_read(rom_addr_o, fault_mode);

    rsig_tester #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SIG_W (16),
        .POLY  (16'h1021),
        .GOLDEN(GOOD)
    ) i_rsig_tester (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rom_addr_o(rom_addr_o),
        .rom_data_i(rom_q),
        .done_o    (done_o),
        .pass_o    (pass_o)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Driver: request a run, queue its expected verdict and done cycle,
    // and follow the address walk (optionally poking start mid-run).
    task automatic start_run(input int mode, input bit poke);
        int c0;
        int bad;
        fault_mode = mode;
        start = 1'b1;
        @(posedge clk);
        #1;
        c0 = cyc;
        exp_pass_q.push_back(stream_sig(mode) == GOOD);
        exp_cyc_q.push_back(c0 + WORDS + 1);
        bad = 0;
        for (int j = 0; j < WORDS; j++) begin
            @(negedge clk);
            start = poke && (j == 5);
            if (rom_addr_o != j[ADDR_W-1:0]) bad++;
        end
        check(bad == 0, "R2 ascending address walk, mismatches", bad, 0);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on every done and judge it (R3 R5 R6 R7).
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(!prev_done, "R6 done wider than one cycle", 1, 0);
                if (exp_pass_q.size() == 0) begin
                    check(1'b0, "R8 stray done", 1, 0);
                end else begin
                    last_pass = exp_pass_q.pop_front();
                    check(pass_o == last_pass, "R7 R5 R3 verdict at done", pass_o, last_pass);
                    check(cyc == exp_cyc_q[0], "R6 done cycle", cyc, exp_cyc_q[0]);
                    void'(exp_cyc_q.pop_front());
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "R6 watchdog expired, run hung", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(done_o == 1'b0, "R1 done in reset", done_o, 0);
        check(pass_o == 1'b0, "R1 pass in reset", pass_o, 0);
        check(rom_addr_o == '0, "R1 address in reset", rom_addr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0 && pass_o == 1'b0, "R1 outputs after reset", {done_o, pass_o}, 0);

        // Fault-free memory passes (R5, R7).
        start_run(0, 1'b0);
        wait_done();
        @(negedge clk);
        check(rom_addr_o == ADDR_W'(WORDS - 1), "R2 address held at top", rom_addr_o, WORDS - 1);
        repeat (3) @(negedge clk);
        check(pass_o == 1'b1, "R7 verdict held after done", pass_o, 1);

        // Each fault is caught (R10).
        for (int m = 1; m <= 4; m++) begin
            start_run(m, 1'b0);
            wait_done();
            check(pass_o == 1'b0, "R10 fault gives fail", pass_o, 0);
            @(negedge clk);
        end

        // Clean run after a failing one passes: reseed works (R4).
        start_run(0, 1'b0);
        wait_done();
        check(pass_o == 1'b1, "R4 reseed after failing run", pass_o, 1);
        @(negedge clk);

        // Start poked mid-run is ignored (R8).
        start_run(0, 1'b1);
        wait_done();
        @(negedge clk);
        repeat (WORDS + 6) @(negedge clk);
        check(exp_pass_q.size() == 0, "R8 no pending or extra run", exp_pass_q.size(), 0);
        check(done_o == 1'b0, "R8 no second done", done_o, 0);

        // Start in the done cycle of a failing run (R9).
        start_run(4, 1'b0);
        wait_done();
        check(pass_o == 1'b0, "R9 old verdict in done cycle", pass_o, 0);
        start_run(0, 1'b0);
        wait_done();
        check(pass_o == 1'b1, "R9 new run after coincident start", pass_o, 1);
        repeat (4) @(negedge clk);
        check(pass_o == last_pass, "R7 final verdict held", pass_o, last_pass);
        check(exp_pass_q.size() == 0, "R6 every run reported done", exp_pass_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule